// File: doc/BRIEF.md
# Fixed-Address Single-Unit DMA Channel

This block is one DMA channel that moves data between a fixed memory location and a fixed I/O location. Each rising request moves exactly one unit, either a byte or a 16-bit word. The memory side uses a full 24-bit address. The I/O side is programmed with 16 bits, and the channel fills in all ones above them. Neither address changes while a job runs. A direction bit decides which side is read and which side is written. A transfer counter sets how many units make up a job. When the counter runs down to zero, the channel switches itself off and raises a done flag, and it can also raise an interrupt.

Software programs the channel through a simple register write port. The channel reaches memory and I/O through a bus master port that uses a valid/ready handshake. For each unit the channel first issues a read beat to the source. It then issues a write beat to the destination, carrying the data it captured from the read. Back-pressure follows one rule: while `bus_valid` is high and `bus_ready` is low, the channel holds the address, direction, size and write data steady. A beat completes on any clock edge where both signals are high.

The request input is sampled only while the channel is idle and fully enabled. Requests that arrive during a unit are dropped, not queued. If a job starts with a count of zero, the counter wraps and the job runs 65536 units.

Top module: `fixed_dma_chan`

## Requirements
- R1: After reset, `done_o`, `err_o`, `irq_o`, `run_o` and `bus_valid` are 0, and `remain_o` is 0.
- R2: The register select on `cfg_addr` decodes as follows: 0 is the memory address (24 bits), 1 is the I/O address (low 16 bits), 2 is the counter (16 bits), 3 is control and 4 is status. The control bits are: bit0 enable, bit1 mode, bit2 idle-mode enable, bit3 direction, bit4 word size, bit5 interrupt enable. A request starts a unit only when bits 0, 1 and 2 are all set. Otherwise the request produces no bus beat and leaves the counter unchanged.
- R3: Each accepted request produces exactly two bus beats: a read from the source, then a write to the destination. The write carries the read data. For a byte transfer, the write carries only the low 8 bits of the read data, with the upper bits zero, and `bus_word` is 0.
- R4: With direction 0, the source is the memory address and the destination is 0xFF followed by the 16-bit I/O address. With direction 1, the two roles swap. Both addresses stay the same on every unit of a job.
- R5: The counter drops by exactly one when each write beat completes. When it reaches 0x0000, the enable bit clears and `done_o` sets.
- R6: `irq_o` equals `done_o` AND the interrupt-enable bit. Writing 1 to status bit0 clears `done_o`. Writing 0 to bit0 leaves it unchanged.
- R7: A word request where either address has bit0 set produces no bus beat. It sets `err_o`, clears the enable bit and leaves the counter unchanged. Writing 1 to status bit1 clears `err_o`.
- R8: A request that is held high or repeated while a unit is in progress is ignored. It does not start an extra unit.
- R9: Writing the enable bit to 0 during a unit lets that unit finish, with its single counter decrement. After that, no further unit starts, and `done_o` stays 0.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_write`, `bus_word` and `bus_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 24 | Register write data |
| xfer_req | input | 1 | Transfer request, level-sampled while idle |
| bus_valid | output | 1 | Bus beat valid |
| bus_ready | input | 1 | Bus beat accepted |
| bus_write | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_word | output | 1 | 1 for word size, 0 for byte size |
| bus_addr | output | 24 | Beat address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid when the read beat completes |
| done_o | output | 1 | Job finished flag |
| err_o | output | 1 | Misaligned word flag |
| irq_o | output | 1 | Interrupt request |
| run_o | output | 1 | Enable bit state |
| remain_o | output | 16 | Transfers remaining |

## Verification
The assertions assume that software does not rewrite the direction bit or the counter while a unit is on the bus. They also assume that `bus_ready` is only raised while `bus_valid` is high. The stimulus always programs a job completely before it issues requests. It changes only the enable bit in the middle of a job. The bus responder in the bench raises ready only after it has seen a valid beat, and it adds between zero and three wait cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  localparam int unsigned RSEL_W = 3;
  localparam logic [RSEL_W-1:0] SEL_MEM  = 3'd0;
  localparam logic [RSEL_W-1:0] SEL_IO   = 3'd1;
  localparam logic [RSEL_W-1:0] SEL_CNT  = 3'd2;
  localparam logic [RSEL_W-1:0] SEL_CTL  = 3'd3;
  localparam logic [RSEL_W-1:0] SEL_STAT = 3'd4;
  localparam int unsigned CTL_W = 6;
  localparam int unsigned STAT_DONE = 0;
  localparam int unsigned STAT_ERR  = 1;

  // bit0 = en ... bit5 = irq_en
  typedef struct packed {
    logic irq_en;
    logic word;
    logic dir;
    logic idle_en;
    logic mode;
    logic en;
  } chan_ctl_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              unit_done,
  input  logic              align_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IO_W-1:0]   io_addr,
  output logic [CNT_W-1:0]  remain,
  output chan_ctl_t         ctl,
  output logic              done,
  output logic              err
);
  logic last_unit;
  logic cnt_load;
  logic stat_wr;

  assign last_unit = unit_done && (remain == CNT_W'(1));
  assign cnt_load  = wr_en && (wr_sel == SEL_CNT);
  assign stat_wr   = wr_en && (wr_sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      io_addr  <= '0;
      remain   <= '0;
      ctl      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_MEM: mem_addr <= wr_data;
          SEL_IO:  io_addr  <= wr_data[IO_W-1:0];
          SEL_CNT: remain   <= wr_data[CNT_W-1:0];
          SEL_CTL: ctl      <= chan_ctl_t'(wr_data[CTL_W-1:0]);
          default: ;
        endcase
      end
      // software load of the counter takes priority over a decrement
      if (!cnt_load && unit_done) remain <= remain - CNT_W'(1);
      // hardware shutdown wins over a simultaneous control write
      if (last_unit || align_err) ctl.en <= 1'b0;
      if (stat_wr && wr_data[STAT_DONE]) done <= 1'b0;
      if (last_unit) done <= 1'b1;
      if (stat_wr && wr_data[STAT_ERR]) err <= 1'b0;
      if (align_err) err <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              req,
  input  logic              word,
  input  logic              dir,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              unit_done,
  output logic              align_err
);
  localparam int unsigned PAD_W  = ADDR_W - IO_W;
  localparam int unsigned LANE_W = 8;

  seq_state_e        state;
  logic [ADDR_W-1:0] io_full;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr;
  logic [DATA_W-1:0] byte_val;
  logic [DATA_W-1:0] hold_q;
  logic              misalign;
  logic              start_ok;

  assign io_full  = {{PAD_W{1'b1}}, io_addr};
  assign src_addr = dir ? io_full : mem_addr;
  assign dst_addr = dir ? mem_addr : io_full;
  assign misalign = word && (mem_addr[0] || io_addr[0]);
  assign start_ok = (state == SEQ_IDLE) && active && req;

  generate
    if (DATA_W > LANE_W) begin : g_wide
      assign byte_val = {{(DATA_W-LANE_W){1'b0}}, bus_rdata[LANE_W-1:0]};
    end else begin : g_narrow
      assign byte_val = bus_rdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      hold_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE:  if (start_ok && !misalign) state <= SEQ_READ;
        SEQ_READ:  if (bus_ready) begin
                     hold_q <= word ? bus_rdata : byte_val;
                     state  <= SEQ_WRITE;
                   end
        SEQ_WRITE: if (bus_ready) state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  assign bus_valid = (state != SEQ_IDLE);
  assign bus_write = (state == SEQ_WRITE);
  assign bus_addr  = bus_write ? dst_addr : src_addr;
  assign bus_wdata = hold_q;
  assign unit_done = (state == SEQ_WRITE) && bus_ready;
  assign align_err = start_ok && misalign;
endmodule

// File: rtl/fixed_dma_chan.sv
module fixed_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              xfer_req,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              run_o,
  output logic [CNT_W-1:0]  remain_o
);
  logic [ADDR_W-1:0] mem_addr;
  logic [IO_W-1:0]   io_addr;
  chan_ctl_t         ctl;
  logic              unit_done;
  logic              align_err;
  logic              active;

  dma_chan_regs #(.ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_addr),
    .wr_data   (cfg_wdata),
    .unit_done (unit_done),
    .align_err (align_err),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .remain    (remain_o),
    .ctl       (ctl),
    .done      (done_o),
    .err       (err_o)
  );

  assign active = ctl.en && ctl.mode && ctl.idle_en;

  dma_chan_seq #(.ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .req       (xfer_req),
    .word      (ctl.word),
    .dir       (ctl.dir),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unit_done (unit_done),
    .align_err (align_err)
  );

  assign bus_word = ctl.word;
  assign irq_o    = done_o && ctl.irq_en;
  assign run_o    = ctl.en;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              dir,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              done_o,
  input logic              err_o,
  input logic              irq_o,
  input logic              run_o,
  input logic [CNT_W-1:0]  remain_o
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write)
      && $stable(bus_word) && $stable(bus_wdata));

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_write |=> bus_valid && bus_write);

  // R4
  io_top_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_write != dir) |-> bus_addr[ADDR_W-1:IO_W] == '1);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) && (remain_o != $past(remain_o)) |-> remain_o == $past(remain_o) - 1'b1);

  // R5
  done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !run_o && remain_o == '0);

  // R6
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  // R7
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !bus_valid && !run_o);
endmodule

bind fixed_dma_chan dma_chan_chk #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .dir       (ctl.dir),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_write (bus_write),
  .bus_word  (bus_word),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .done_o    (done_o),
  .err_o     (err_o),
  .irq_o     (irq_o),
  .run_o     (run_o),
  .remain_o  (remain_o)
);

// File: tb/test_fixed_dma_chan.sv
`timescale 1ns/1ps
module test_fixed_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        xfer_req = 1'b0;
  logic        bus_valid, bus_write, bus_word;
  logic        bus_ready = 1'b0;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        done_o, err_o, irq_o, run_o;
  logic [15:0] remain_o;

  int n_chk = 0;
  int n_err = 0;
  int lat = 0;
  int wait_cnt = 0;
  int nbeats = 0;
  logic [23:0] lg_addr [32];
  logic        lg_wr   [32];
  logic        lg_word [32];
  logic [15:0] lg_data [32];

  // control bits: en=1, mode=2, idle=4, dir=8, word=16, irq=32
  localparam logic [23:0] C_RUN = 24'h7;

  // {dir, word, irq_en, mem addr, io addr, count}
  localparam logic [46:0] VEC [4] = '{
    {1'b0, 1'b0, 1'b1, 24'h123457, 16'h0011, 4'd3},
    {1'b1, 1'b0, 1'b0, 24'hA00001, 16'h8003, 4'd2},
    {1'b0, 1'b1, 1'b1, 24'h004000, 16'hFFFE, 4'd2},
    {1'b1, 1'b1, 1'b0, 24'h3C0F02, 16'h0100, 4'd1}
  };

  fixed_dma_chan i_fixed_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_o(done_o), .err_o(err_o), .irq_o(irq_o), .run_o(run_o),
    .remain_o(remain_o)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ 16'hC35A ^ {a[23:16], 8'h00};
  endfunction

  // bus responder: ready after lat wait cycles, logs each beat
  initial begin
    forever begin
      @(negedge clk);
      bus_ready = 1'b0;
      if (bus_valid) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          bus_ready = 1'b1;
          bus_rdata = pat(bus_addr);
          if (nbeats < 32) begin
            lg_addr[nbeats] = bus_addr;
            lg_wr[nbeats]   = bus_write;
            lg_word[nbeats] = bus_word;
            lg_data[nbeats] = bus_wdata;
          end
          nbeats++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req(input int cycles);
    @(negedge clk);
    xfer_req = 1'b1;
    repeat (cycles) @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic wait_beats(input int target);
    while (nbeats < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=done", nbeats);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 done", done_o, 0);
    chk_eq("R1 err", err_o, 0);
    chk_eq("R1 irq", irq_o, 0);
    chk_eq("R1 run", run_o, 0);
    chk_eq("R1 valid", bus_valid, 0);
    chk_eq("R1 remain", remain_o, 0);

    // vector table: R3 R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      logic        dir, word, irqe;
      logic [23:0] mem, src, dst, expd;
      logic [15:0] io;
      int          cnt;
      {dir, word, irqe, mem, io} = VEC[v][46:4];
      cnt = int'(VEC[v][3:0]);
      src = dir ? {8'hFF, io} : mem;
      dst = dir ? mem : {8'hFF, io};
      lat = v % 3;
      cfg(3'd4, 24'h3);
      cfg(3'd0, mem);
      cfg(3'd1, {8'h00, io});
      cfg(3'd2, 24'(cnt));
      cfg(3'd3, C_RUN | {18'd0, irqe, word, dir, 3'd0});
      nbeats = 0;
      for (int k = 0; k < cnt; k++) begin
        pulse_req(1);
        wait_beats(2 * (k + 1));
      end
      chk_eq("R3 beat count", nbeats, 2 * cnt);
      for (int b = 0; b < 2 * cnt; b++) begin
        chk_eq("R3 beat kind", lg_wr[b], b % 2);
        chk_eq("R3 beat size", lg_word[b], word);
        chk_eq("R4 beat addr", lg_addr[b], (b % 2) ? dst : src);
        if (b % 2 == 1) begin
          expd = word ? {8'h0, pat(src)} : {16'h0, 8'h00, pat(src)[7:0]};
          chk_eq("R3 write data", lg_data[b], expd);
        end
      end
      chk_eq("R5 remain zero", remain_o, 0);
      chk_eq("R5 done set", done_o, 1);
      chk_eq("R5 enable cleared", run_o, 0);
      chk_eq("R6 irq", irq_o, irqe);
    end

    // R6 done clear
    cfg(3'd0, 24'h000010);
    cfg(3'd1, 24'h000020);
    cfg(3'd2, 24'd1);
    cfg(3'd3, C_RUN | 24'h20);
    lat = 0; nbeats = 0;
    pulse_req(1);
    wait_beats(2);
    chk_eq("R6 irq with done", irq_o, 1);
    cfg(3'd4, 24'h2);
    chk_eq("R6 done kept on bit1 write", done_o, 1);
    cfg(3'd4, 24'h1);
    chk_eq("R6 done cleared", done_o, 0);
    chk_eq("R6 irq cleared", irq_o, 0);

    // R2 mode bit clear: no operation
    cfg(3'd2, 24'd3);
    cfg(3'd3, 24'h5);
    nbeats = 0;
    pulse_req(1);
    repeat (10) @(negedge clk);
    chk_eq("R2 no beat without mode", nbeats, 0);
    chk_eq("R2 remain unchanged", remain_o, 3);
    cfg(3'd3, 24'h3);
    pulse_req(1);
    repeat (10) @(negedge clk);
    chk_eq("R2 no beat without idle enable", nbeats, 0);

    // R7 misaligned word
    cfg(3'd0, 24'h000101);
    cfg(3'd2, 24'd2);
    cfg(3'd3, C_RUN | 24'h10);
    pulse_req(1);
    repeat (6) @(negedge clk);
    chk_eq("R7 no beat", nbeats, 0);
    chk_eq("R7 err set", err_o, 1);
    chk_eq("R7 enable cleared", run_o, 0);
    chk_eq("R7 remain unchanged", remain_o, 2);
    cfg(3'd4, 24'h2);
    chk_eq("R7 err cleared", err_o, 0);

    // R8 request held during a unit
    cfg(3'd0, 24'h000200);
    cfg(3'd2, 24'd4);
    cfg(3'd3, C_RUN);
    lat = 3; nbeats = 0;
    pulse_req(3);
    repeat (20) @(negedge clk);
    chk_eq("R8 one unit only", nbeats, 2);
    chk_eq("R8 remain", remain_o, 3);

    // R9 disable mid-unit
    cfg(3'd2, 24'd5);
    cfg(3'd3, C_RUN);
    nbeats = 0;
    pulse_req(1);
    cfg(3'd3, 24'h6);
    repeat (20) @(negedge clk);
    chk_eq("R9 unit finished", nbeats, 2);
    chk_eq("R9 remain", remain_o, 4);
    chk_eq("R9 stopped", run_o, 0);
    chk_eq("R9 no done", done_o, 0);
    pulse_req(1);
    repeat (10) @(negedge clk);
    chk_eq("R9 no further unit", nbeats, 2);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule